// File: doc/BRIEF.md
# Lens Command Repeater

This block sits between a host register interface and a detachable lens. The host places a 32-bit command word on a plain input, then raises a start bit in a control byte. The block sends the four command bytes over an outbound byte stream. It then gathers the lens reply, which is a stream of bytes of any length (zero included), into an internal FIFO. The host drains the FIFO one byte at a time by toggling a pop bit, and reads the head byte on a read-data port.

A 32-bit status word reports the following:
- lens presence
- completion
- FIFO empty and full
- a checksum mismatch
- a reply timeout
- the number of bytes held in the FIFO

The lens link is kept abstract. It consists of an outbound byte with valid/ready, an inbound byte with valid only, a lens-present level and an end-of-reply strobe. The outbound stream obeys normal valid/ready rules. Once `tx_valid_o` is high, the byte and the valid stay unchanged until `tx_ready_i` is sampled high. The inbound stream has no back-pressure: a byte that arrives while the FIFO is full is lost.

Top module: `lens_cmd_relay`

## Requirements
- R1: After an accepted start, the block transmits exactly four bytes, in this order: `cmd_word_i[31:24]` (type), then `[23:16]` (code), then `[15:8]` (first parameter), then `[7:0]` (second parameter). A byte and `tx_valid_o` are held unchanged until the cycle in which `tx_ready_i` is high.
- R2: A command starts only on a 0-to-1 change of control bit 0, and only while ready is set and no command is in progress. Any other start is ignored. An accepted start clears status bits 1, 4 and 5.
- R3: Status bit 0 (ready) follows the lens-present input with one cycle of delay. When ready is low, any command in progress is abandoned without setting done.
- R4: Each inbound byte received while a reply is being collected is appended to the FIFO. Status bits 23:16 give the byte count, bit 2 is set when the FIFO is empty and bit 3 is set when it holds `FIFO_DEPTH` bytes. A byte that arrives while the FIFO is full is dropped.
- R5: A 0-to-1 change of control bit 1 removes the head byte. A pop with the FIFO empty changes nothing. `rd_data_o` shows the head byte.
- R6: The end-of-reply strobe during collection sets status bit 1 (done) and ends the command. A byte that arrives in the same cycle as the strobe belongs to the reply.
- R7: At the end of a reply holding at least one byte, status bit 4 is set if the final byte differs from the unsigned 8-bit sum of the bytes before it. An empty reply leaves bit 4 clear.
- R8: If `tmo_limit_i` consecutive collection cycles pass with no byte and no strobe, status bits 5 and 1 are both set and the command ends.
- R9: While control bit 7 is set, the block is held cleared. Ready, done and the error flags are 0, the FIFO is empty and no command runs.
- R10: An inbound byte that arrives when no reply is being collected is neither stored in the FIFO nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word_i | input | 32 | Command word: type, code, parameter 1, parameter 2 from high byte to low byte |
| ctrl_i | input | 8 | Control: bit 0 start, bit 1 pop, bit 7 block clear |
| tmo_limit_i | input | TMO_W | Idle cycles allowed while waiting for reply bytes (at least 1) |
| status_o | output | 32 | Status: bit 0 ready, 1 done, 2 empty, 3 full, 4 checksum error, 5 timeout, 23:16 count |
| rd_data_o | output | 8 | FIFO head byte |
| tx_data_o | output | 8 | Outbound command byte |
| tx_valid_o | output | 1 | Outbound byte valid |
| tx_ready_i | input | 1 | Lens side accepts the outbound byte |
| rx_data_i | input | 8 | Inbound reply byte |
| rx_valid_i | input | 1 | Inbound byte valid |
| rsp_end_i | input | 1 | End-of-reply strobe |
| lens_present_i | input | 1 | Lens attached |

## Verification
The bench builds the block with a six-byte FIFO and drives a timeout limit of five cycles. With these values, filling the FIFO and dropping the excess bytes takes only a few cycles. A silent lens triggers the timeout path within a short run.

The bench also covers the following cases:
- outbound handshakes under alternating back-pressure
- a good checksum, a bad checksum and an empty reply
- a final byte arriving in the same cycle as the strobe
- a lens removed while a command is in flight
- a block clear during collection

// File: rtl/lcr_pkg.sv
package lcr_pkg;
  typedef enum logic [1:0] {
    LS_IDLE    = 2'd0,
    LS_SEND    = 2'd1,
    LS_COLLECT = 2'd2
  } link_state_e;

  localparam int CTL_START = 0;
  localparam int CTL_POP   = 1;
  localparam int CTL_CLEAR = 7;

  localparam int ST_READY = 0;
  localparam int ST_DONE  = 1;
  localparam int ST_EMPTY = 2;
  localparam int ST_FULL  = 3;
  localparam int ST_CRC   = 4;
  localparam int ST_TMO   = 5;
  localparam int ST_CNT_L = 16;
endpackage

// File: rtl/lcr_fifo.sv
module lcr_fifo #(
  parameter int DEPTH = 255
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr_i,
  input  logic                           push_i,
  input  logic [7:0]                     data_i,
  input  logic                           pop_i,
  output logic [7:0]                     data_o,
  output logic [$clog2(DEPTH+1)-1:0]     count_o,
  output logic                           empty_o,
  output logic                           full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign count_o = cnt;
  assign data_o  = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clr_i) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr_i) mem[wptr] <= data_i;
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(DEPTH));

  p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i && !clr_i) |=> empty_o);

  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i && !clr_i) |=> (full_o && $stable(wptr)));
endmodule

// File: rtl/lcr_link.sv
module lcr_link
  import lcr_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             ready_i,
  input  logic             go_i,
  input  logic [31:0]      cmd_i,
  input  logic [TMO_W-1:0] tmo_lim_i,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_valid_i,
  input  logic             rsp_end_i,
  output logic             push_o,
  output logic [7:0]       push_data_o,
  output logic             done_o,
  output logic             crc_err_o,
  output logic             tmo_err_o
);
  link_state_e      state;
  logic [1:0]       idx;
  logic [31:0]      cmd_q;
  logic [TMO_W-1:0] timer;
  logic [7:0]       acc, last;
  logic             got;
  logic [7:0]       n_acc, n_last;
  logic             n_got;

  assign tx_valid_o  = (state == LS_SEND);
  assign push_o      = (state == LS_COLLECT) && rx_valid_i;
  assign push_data_o = rx_data_i;

  always_comb begin
    case (idx)
      2'd0:    tx_data_o = cmd_q[31:24];
      2'd1:    tx_data_o = cmd_q[23:16];
      2'd2:    tx_data_o = cmd_q[15:8];
      default: tx_data_o = cmd_q[7:0];
    endcase
  end

  always_comb begin
    n_acc  = acc;
    n_last = last;
    n_got  = got;
    if (rx_valid_i) begin
      n_acc  = got ? acc + last : acc;
      n_last = rx_data_i;
      n_got  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LS_IDLE; idx <= '0; cmd_q <= '0; timer <= '0;
      acc <= '0; last <= '0; got <= 1'b0;
      done_o <= 1'b0; crc_err_o <= 1'b0; tmo_err_o <= 1'b0;
    end else if (clr_i) begin
      state <= LS_IDLE; idx <= '0; timer <= '0;
      acc <= '0; last <= '0; got <= 1'b0;
      done_o <= 1'b0; crc_err_o <= 1'b0; tmo_err_o <= 1'b0;
    end else if (!ready_i) begin
      state <= LS_IDLE;
    end else begin
      case (state)
        LS_IDLE: if (go_i) begin
          cmd_q <= cmd_i; idx <= '0; state <= LS_SEND;
          done_o <= 1'b0; crc_err_o <= 1'b0; tmo_err_o <= 1'b0;
          acc <= '0; got <= 1'b0;
        end
        LS_SEND: if (tx_ready_i) begin
          if (idx == 2'd3) begin
            state <= LS_COLLECT;
            timer <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        LS_COLLECT: begin
          if (rx_valid_i) begin
            acc <= n_acc; last <= n_last; got <= n_got; timer <= '0;
          end
          if (rsp_end_i) begin
            done_o    <= 1'b1;
            crc_err_o <= n_got && (n_acc != n_last);
            state     <= LS_IDLE;
          end else if (!rx_valid_i) begin
            if (timer == tmo_lim_i - 1'b1) begin
              done_o    <= 1'b1;
              tmo_err_o <= 1'b1;
              state     <= LS_IDLE;
            end else begin
              timer <= timer + 1'b1;
            end
          end
        end
        default: state <= LS_IDLE;
      endcase
    end
  end

  p_tx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i && ready_i && !clr_i) |=> (tx_valid_o && $stable(tx_data_o)));

  p_four_bytes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && tx_ready_i && idx == 2'd3 && ready_i && !clr_i) |=> !tx_valid_o);

  p_idle_without_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_IDLE && !ready_i) |=> (state == LS_IDLE));

  p_tmo_sets_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err_o) |-> done_o);
endmodule

// File: rtl/lens_cmd_relay.sv
module lens_cmd_relay
  import lcr_pkg::*;
#(
  parameter int FIFO_DEPTH = 255,
  parameter int TMO_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cmd_word_i,
  input  logic [7:0]       ctrl_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  output logic [31:0]      status_o,
  output logic [7:0]       rd_data_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_valid_i,
  input  logic             rsp_end_i,
  input  logic             lens_present_i
);
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);

  logic             ready_q, prev_start, prev_pop;
  logic             clr, go, pop_edge;
  logic             push;
  logic [7:0]       push_data;
  logic [CNT_W-1:0] count;
  logic             empty, full, done, crc_err, tmo_err;
  logic             unused_ctrl;

  assign clr         = ctrl_i[CTL_CLEAR];
  assign go          = ctrl_i[CTL_START] && !prev_start && ready_q;
  assign pop_edge    = ctrl_i[CTL_POP] && !prev_pop;
  assign unused_ctrl = ^ctrl_i[6:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q    <= 1'b0;
      prev_start <= 1'b0;
      prev_pop   <= 1'b0;
    end else begin
      ready_q    <= lens_present_i && !clr;
      prev_start <= ctrl_i[CTL_START];
      prev_pop   <= ctrl_i[CTL_POP];
    end
  end

  lcr_link #(.TMO_W(TMO_W)) u_link (
    .clk, .rst_n,
    .clr_i(clr), .ready_i(ready_q), .go_i(go), .cmd_i(cmd_word_i),
    .tmo_lim_i(tmo_limit_i),
    .tx_data_o, .tx_valid_o, .tx_ready_i,
    .rx_data_i, .rx_valid_i, .rsp_end_i,
    .push_o(push), .push_data_o(push_data),
    .done_o(done), .crc_err_o(crc_err), .tmo_err_o(tmo_err)
  );

  lcr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n, .clr_i(clr),
    .push_i(push), .data_i(push_data), .pop_i(pop_edge),
    .data_o(rd_data_o), .count_o(count), .empty_o(empty), .full_o(full)
  );

  always_comb begin
    status_o                         = '0;
    status_o[ST_READY]               = ready_q;
    status_o[ST_DONE]                = done;
    status_o[ST_EMPTY]               = empty;
    status_o[ST_FULL]                = full;
    status_o[ST_CRC]                 = crc_err;
    status_o[ST_TMO]                 = tmo_err;
    status_o[ST_CNT_L +: 8]          = 8'(count);
  end

  p_block_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (status_o[5:0] == 6'b000100 && status_o[23:16] == 8'd0));

  p_ready_tracks_lens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lens_present_i) |=> !status_o[ST_READY]);
endmodule

// File: tb/test_lens_cmd_relay.sv
module test_lens_cmd_relay;
  localparam int DEPTH = 6;
  localparam int TW    = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   cmd = '0;
  logic [7:0]    ctrl = '0;
  logic [TW-1:0] lim = 16'd5;
  logic [31:0]   status;
  logic [7:0]    rdd, txd, rxd = '0;
  logic          txv, txr = 1'b1, rxv = 1'b0, rend = 1'b0, lens = 1'b0;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  lens_cmd_relay #(.FIFO_DEPTH(DEPTH), .TMO_W(TW)) i_lens_cmd_relay (
    .clk, .rst_n, .cmd_word_i(cmd), .ctrl_i(ctrl), .tmo_limit_i(lim),
    .status_o(status), .rd_data_o(rdd), .tx_data_o(txd), .tx_valid_o(txv),
    .tx_ready_i(txr), .rx_data_i(rxd), .rx_valid_i(rxv), .rsp_end_i(rend),
    .lens_present_i(lens)
  );

  // behavioural reference model
  bit       m_ready, m_done, m_crc, m_tmo, m_ps, m_pp, m_got;
  int       m_state, m_idx, m_timer;
  bit [31:0] m_cmd;
  bit [7:0] m_acc, m_last;
  bit [7:0] q[$];

  always @(posedge clk) begin
    bit se, pe, full_pre, push;
    bit [7:0] na, nl;
    bit ng;
    if (!rst_n) begin
      m_ready = 0; m_done = 0; m_crc = 0; m_tmo = 0; m_ps = 0; m_pp = 0;
      m_state = 0; m_idx = 0; m_timer = 0; m_got = 0; m_acc = 0; m_last = 0;
      q.delete();
    end else if (ctrl[7]) begin
      m_ready = 0; m_done = 0; m_crc = 0; m_tmo = 0; m_state = 0; m_idx = 0;
      m_got = 0; m_acc = 0; q.delete();
      m_ps = ctrl[0]; m_pp = ctrl[1];
    end else begin
      se = ctrl[0] && !m_ps;
      pe = ctrl[1] && !m_pp;
      full_pre = (q.size() == DEPTH);
      push = (m_state == 2) && rxv;
      if (pe && q.size() > 0) void'(q.pop_front());
      if (push && !full_pre) q.push_back(rxd);
      if (!m_ready) m_state = 0;
      else if (m_state == 0) begin
        if (se) begin
          m_cmd = cmd; m_idx = 0; m_state = 1; m_done = 0; m_crc = 0; m_tmo = 0;
          m_acc = 0; m_got = 0;
        end
      end else if (m_state == 1) begin
        if (txr) begin
          if (m_idx == 3) begin m_state = 2; m_timer = 0; end
          else m_idx++;
        end
      end else begin
        na = m_acc; nl = m_last; ng = m_got;
        if (rxv) begin
          na = m_got ? m_acc + m_last : m_acc; nl = rxd; ng = 1;
          m_acc = na; m_last = nl; m_got = 1; m_timer = 0;
        end
        if (rend) begin
          m_done = 1; m_crc = ng && (na != nl); m_state = 0;
        end else if (!rxv) begin
          if (m_timer == int'(lim) - 1) begin m_done = 1; m_tmo = 1; m_state = 0; end
          else m_timer++;
        end
      end
      m_ready = lens;
      m_ps = ctrl[0]; m_pp = ctrl[1];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit [7:0] eb;
    cyc++;
    if (rst_n) begin
      chk("R3 ready", 32'(status[0]), 32'(m_ready));
      chk("R6 done", 32'(status[1]), 32'(m_done));
      chk("R4 empty", 32'(status[2]), 32'(q.size() == 0));
      chk("R4 full", 32'(status[3]), 32'(q.size() == DEPTH));
      chk("R7 checksum flag", 32'(status[4]), 32'(m_crc));
      chk("R8 timeout flag", 32'(status[5]), 32'(m_tmo));
      chk("R4 count", 32'(status[23:16]), 32'(q.size()));
      chk("R1 tx valid", 32'(txv), 32'(m_state == 1));
      if (m_state == 1) begin
        case (m_idx)
          0: eb = m_cmd[31:24];
          1: eb = m_cmd[23:16];
          2: eb = m_cmd[15:8];
          default: eb = m_cmd[7:0];
        endcase
        chk("R1 tx byte", 32'(txd), 32'(eb));
      end
      if (q.size() > 0) chk("R5 head byte", 32'(rdd), 32'(q[0]));
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start(logic [31:0] c);
    ctrl[0] = 1'b0; tick(1);
    cmd = c; ctrl[0] = 1'b1; tick(1);
    ctrl[0] = 1'b0;
  endtask

  task automatic rx_byte(logic [7:0] b, bit with_end);
    rxd = b; rxv = 1'b1; rend = with_end; tick(1);
    rxv = 1'b0; rend = 1'b0; tick(1);
  endtask

  task automatic end_rsp();
    rend = 1'b1; tick(1); rend = 1'b0; tick(2);
  endtask

  task automatic pop_n(int n);
    for (int i = 0; i < n; i++) begin
      ctrl[1] = 1'b1; tick(1); ctrl[1] = 1'b0; tick(1);
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R9 reset status", status, 32'h0000_0004);
    // R2: start without a lens is ignored
    start(32'h0A0B0C0D); tick(2);
    chk("R2 ignored start", 32'(txv), 32'd0);
    lens = 1'b1; tick(3);
    // R1: packed fields 1,2,3,4 under alternating back-pressure
    txr = 1'b0;
    start(32'h04030201);
    for (int i = 0; i < 10; i++) begin txr = i[0]; tick(1); end
    txr = 1'b1; tick(3);
    // R7: good checksum 10+20+30 = 60
    rx_byte(8'h10, 0); rx_byte(8'h20, 0); rx_byte(8'h30, 0); rx_byte(8'h60, 0);
    end_rsp();
    chk("R7 good sum", 32'(status[4]), 32'd0);
    pop_n(5);                     // R5: last pop on an empty FIFO
    // R6/R7: bad checksum, final byte with the strobe
    start(32'h11223344); tick(6);
    rx_byte(8'h05, 0); rx_byte(8'hFF, 0); rx_byte(8'h07, 1); tick(2);
    chk("R7 bad sum", 32'(status[4]), 32'd1);
    // R10: byte while idle is not stored
    rx_byte(8'hAA, 0);
    chk("R10 idle byte", 32'(status[23:16]), 32'd3);
    // zero-length reply
    start(32'h55667788); tick(6);
    end_rsp();
    chk("R6 empty reply done", 32'(status[1]), 32'd1);
    // R8: timeout
    start(32'h99AABBCC); tick(20);
    chk("R8 timeout", 32'(status[5]), 32'd1);
    // R4: overflow drops bytes
    start(32'hDEADBEEF); tick(6);
    for (int i = 0; i < 6; i++) rx_byte(8'(8'h40 + i), 0);
    end_rsp();
    chk("R4 full count", 32'(status[23:16]), 32'(DEPTH));
    pop_n(DEPTH + 1);
    // R2: start while busy is ignored
    start(32'h01020304); tick(6);
    start(32'hF0F0F0F0); tick(1);
    chk("R2 busy start", 32'(txv), 32'd0);
    rx_byte(8'h21, 0);
    // R9: block clear mid-reply
    ctrl[7] = 1'b1; tick(2);
    chk("R9 block clear", status, 32'h0000_0004);
    ctrl[7] = 1'b0; tick(3);
    // R3: lens removed during a command
    start(32'h0F0E0D0C); tick(2);
    lens = 1'b0; tick(3);
    chk("R3 detach", 32'(status[0]), 32'd0);
    lens = 1'b1; tick(3);
    start(32'h01010101); tick(6);
    rx_byte(8'h01, 0); rx_byte(8'h01, 1); tick(2);
    pop_n(3);
    tick(4);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule